// File: doc/BRIEF.md
# Serial Register Port with Burst Addressing

This block is the host-facing slave port of a timekeeping peripheral. A host selects it with `sel`, drives a serial clock on `sck` and data on `sdi`, and receives data on `sdo`. Inside the chip the port drives a parallel address, data and strobe interface. That interface reaches a 32-byte general-purpose RAM and a bank of clock registers. The calendar logic and the storage arrays are outside this block.

Each transfer starts with one header byte that holds a direction flag and a start address. Any number of data bytes follow. After each complete data byte the port moves to the next location, so a whole block of RAM or registers can be read or written from a single start address. The address wraps inside the RAM region and inside the register region. While the device is in its power-down state, the port ignores all serial traffic.

The serial pins are asynchronous to `clk` and pass through a synchronizer. For that reason, `sck` must stay high for at least 8 `clk` cycles and low for at least 8 `clk` cycles. `sdi` must be stable around each rising edge of `sck`. The external storage returns `bus_rdata` one `clk` cycle after a cycle in which `bus_re` is high.

Top module: `rsp_serial_port`

## Requirements
- R1: While reset is low and in the first cycle after reset, `sdo`, `bus_we` and `bus_re` are all 0.
- R2: Data moves MSB first. `sdi` is sampled on rising edges of `sck`. The first byte after `sel` rises is the header: bit 7 set means write, bit 7 clear means read, and bits 6..0 are the start address.
- R3: In a write transfer, each complete data byte produces exactly one single-cycle `bus_we` pulse. The pulse carries the byte on `bus_wdata` and the current location on `bus_addr`.
- R4: In a read transfer, the byte at the current location is presented on `sdo` MSB first. `sdo` changes on falling edges of `sck`. The first bit appears on the falling edge that follows the last bit of the header or of the previous data byte.
- R5: After each complete data byte the location advances by one, so consecutive bytes of a burst reach consecutive addresses.
- R6: The RAM occupies addresses 0x00 to 0x1F. Advancing from 0x1F goes to 0x00.
- R7: The clock registers occupy addresses 0x20 to 0x2F. Advancing from 0x2F goes to 0x20.
- R8: Addresses 0x30 to 0x7F are unmapped. They produce no `bus_we` or `bus_re`, read as 0x00, and advance by one, with 0x7F advancing to 0x00.
- R9: If `sel` falls before a byte is complete, that byte produces no write. The next assertion of `sel` starts a new header.
- R10: While `pwr_down` is 1, the port produces no strobes and keeps `sdo` at 0. A transfer made during power-down leaves no state behind.
- R11: While `sel` is 0, `sdo` is 0 and `sck` activity has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_down | input | 1 | Power-down state; the port is disabled while it is 1 |
| sel | input | 1 | Slave select from the host, active high |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| bus_addr | output | 7 | Parallel location address |
| bus_we | output | 1 | Single-cycle write strobe |
| bus_re | output | 1 | Single-cycle read strobe |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid one cycle after `bus_re` |

## Verification
Counted from the `clk` cycle in which a rising edge of `sck` first appears at the pin, the `bus_we` pulse for that byte is due four cycles later. Counted the same way, the next read byte is loaded into the output shifter seven cycles later. A falling edge of `sck` moves a new bit onto `sdo` three cycles after the edge. The bench holds each `sck` phase for 10 `clk` cycles and samples `sdo` at the moment it raises `sck`, which is well after the bit has settled. A monitor inspects the strobes at every falling `clk` edge and matches each write in order against a queue of expected writes. Any write with no queued entry, including one made during power-down or after an aborted byte, counts as a failure.

// File: rtl/rsp_pkg.sv
// Package: shared types of the serial register port.
// Assumes nothing beyond IEEE 1800-2017 enums.
package rsp_pkg;

    // Transfer phase: header byte first, then a data direction.
    typedef enum logic [1:0] {
        PH_HEADER = 2'd0,
        PH_WRITE  = 2'd1,
        PH_READ   = 2'd2
    } phase_t;

endpackage

// File: rtl/rsp_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous pins.
// Assumes each bit is an independent level; a parameter picks the depth.
module rsp_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        if (STAGES == 1) begin : g_single
            logic [WIDTH-1:0] stage_q;

            // Capture the pins in a single register stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= d;
            end

            assign q = stage_q;
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] chain_q;

            // Shift the pins through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end

            assign q = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/rsp_rx_shift.sv
// Module: receive shifter; assembles MSB-first bytes from sampled bits.
// Assumes 'sample' is a one-cycle pulse per rising serial clock edge;
// dropping 'active' discards any partial byte.
module rsp_rx_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              sample,
    input  logic              din,
    output logic              byte_done,
    output logic [DATA_W-1:0] byte_q
);

    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] shift_q;

    // Count bits, shift them in, and flag each finished byte.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            bit_cnt   <= '0;
            shift_q   <= '0;
            byte_done <= 1'b0;
            byte_q    <= '0;
        end else begin
            byte_done <= 1'b0;
            if (sample) begin
                shift_q <= {shift_q[DATA_W-2:0], din};
                if (bit_cnt == LAST_BIT) begin
                    bit_cnt   <= '0;
                    byte_done <= 1'b1;
                    byte_q    <= {shift_q[DATA_W-2:0], din};
                end else begin
                    bit_cnt <= bit_cnt + CNT_W'(1);
                end
            end
        end
    end

    // R9: a finished byte needs the port to have been active in the prior cycle
    a_r9_byte_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> $past(active));

endmodule

// File: rtl/rsp_tx_shift.sv
// Module: transmit shifter; drives the serial output MSB first.
// Assumes 'load' and 'shift' never coincide (the serial clock phase
// requirement keeps them apart); load wins if they do.
module rsp_tx_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              shift,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              sdo
);

    logic [DATA_W-1:0] tx_q;
    logic              sdo_q;

    // Load a fetched byte or move the next bit out on a falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            tx_q  <= '0;
            sdo_q <= 1'b0;
        end else if (load) begin
            tx_q <= load_data;
        end else if (shift) begin
            sdo_q <= tx_q[DATA_W-1];
            tx_q  <= {tx_q[DATA_W-2:0], 1'b0};
        end
    end

    assign sdo = sdo_q;

    // R11: after an inactive cycle the output line is low
    a_r11_sdo_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !sdo);

endmodule

// File: rtl/rsp_ctrl.sv
// Module: transfer controller; decodes the header, tracks the burst
// location with region wrap, and issues write and read strobes.
// Assumes bus_rdata is valid one cycle after bus_re and that
// ADDR_W is smaller than DATA_W (the top bit of the header is the flag).
module rsp_ctrl
    import rsp_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int DATA_W    = 8,
    parameter int RAM_DEPTH = 32,
    parameter int REG_BASE  = 32,
    parameter int REG_COUNT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              byte_done,
    input  logic [DATA_W-1:0] byte_in,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_we,
    output logic              bus_re,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              load,
    output logic [DATA_W-1:0] load_data
);

    localparam logic [ADDR_W-1:0] RAM_LAST_A = ADDR_W'(RAM_DEPTH - 1);
    localparam logic [ADDR_W-1:0] REG_BASE_A = ADDR_W'(REG_BASE);
    localparam logic [ADDR_W-1:0] REG_LAST_A = ADDR_W'(REG_BASE + REG_COUNT - 1);

    // True when the address falls in the RAM or the register region.
    function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
        return (a <= RAM_LAST_A) || ((a >= REG_BASE_A) && (a <= REG_LAST_A));
    endfunction

    // Next burst location, wrapping inside each region.
    function automatic logic [ADDR_W-1:0] next_loc(input logic [ADDR_W-1:0] a);
        if (a == RAM_LAST_A)      return '0;
        else if (a == REG_LAST_A) return REG_BASE_A;
        else                      return a + ADDR_W'(1);
    endfunction

    phase_t            phase;
    logic [ADDR_W-1:0] loc_q;
    logic              fetch_q;
    logic              issue_q;
    logic              map_q;
    logic              we_q;
    logic              re_q;
    logic              load_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    // Decode the header and step the burst location after each byte.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            phase   <= PH_HEADER;
            loc_q   <= '0;
            fetch_q <= 1'b0;
        end else begin
            fetch_q <= 1'b0;
            if (byte_done) begin
                unique case (phase)
                    PH_HEADER: begin
                        loc_q <= byte_in[ADDR_W-1:0];
                        if (byte_in[DATA_W-1]) begin
                            phase <= PH_WRITE;
                        end else begin
                            phase   <= PH_READ;
                            fetch_q <= 1'b1;
                        end
                    end
                    PH_WRITE: loc_q <= next_loc(loc_q);
                    PH_READ: begin
                        loc_q   <= next_loc(loc_q);
                        fetch_q <= 1'b1;
                    end
                    default: phase <= PH_HEADER;
                endcase
            end
        end
    end

    // Drive the parallel strobes, address and write data.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            we_q    <= 1'b0;
            re_q    <= 1'b0;
            issue_q <= 1'b0;
            load_q  <= 1'b0;
            map_q   <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            we_q    <= 1'b0;
            re_q    <= 1'b0;
            issue_q <= 1'b0;
            load_q  <= issue_q;
            if (byte_done && (phase == PH_WRITE)) begin
                we_q    <= is_mapped(loc_q);
                addr_q  <= loc_q;
                wdata_q <= byte_in;
            end
            if (fetch_q) begin
                re_q    <= is_mapped(loc_q);
                map_q   <= is_mapped(loc_q);
                addr_q  <= loc_q;
                issue_q <= 1'b1;
            end
        end
    end

    assign bus_addr  = addr_q;
    assign bus_we    = we_q;
    assign bus_re    = re_q;
    assign bus_wdata = wdata_q;
    assign load      = load_q;
    assign load_data = map_q ? bus_rdata : '0;

    // R3: a write strobe follows a byte completed by the receive shifter
    a_r3_we_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> $past(byte_done));

    // R3: write and read strobes never overlap
    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_re));

    // R8: strobes only reach mapped locations
    a_r8_strobe_mapped: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we || bus_re) |-> is_mapped(bus_addr));

endmodule

// File: rtl/rsp_serial_port.sv
// Module: top of the serial register port. It synchronizes the host pins,
// detects serial clock edges and joins the receive shifter, the
// controller and the transmit shifter.
// Assumes each serial clock phase lasts at least 8 clk cycles.
module rsp_serial_port #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int RAM_DEPTH   = 32,
    parameter int REG_BASE    = 32,
    parameter int REG_COUNT   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_down,
    input  logic              sel,
    input  logic              sck,
    input  logic              sdi,
    output logic              sdo,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_we,
    output logic              bus_re,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata
);

    logic [2:0]        pins_s;
    logic              sck_s;
    logic              sel_s;
    logic              sdi_s;
    logic              sck_q;
    logic              sck_rise;
    logic              sck_fall;
    logic              active;
    logic              byte_done;
    logic [DATA_W-1:0] byte_q;
    logic              load;
    logic [DATA_W-1:0] load_data;

    rsp_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sdi, sel, sck}),
        .q     (pins_s)
    );

    assign sck_s = pins_s[0];
    assign sel_s = pins_s[1];
    assign sdi_s = pins_s[2];

    // Remember the last synchronized serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_s;
    end

    assign sck_rise = sck_s & ~sck_q;
    assign sck_fall = ~sck_s & sck_q;
    assign active   = sel_s & ~pwr_down;

    rsp_rx_shift #(
        .DATA_W (DATA_W)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .sample    (sck_rise),
        .din       (sdi_s),
        .byte_done (byte_done),
        .byte_q    (byte_q)
    );

    rsp_ctrl #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .RAM_DEPTH (RAM_DEPTH),
        .REG_BASE  (REG_BASE),
        .REG_COUNT (REG_COUNT)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .byte_done (byte_done),
        .byte_in   (byte_q),
        .bus_rdata (bus_rdata),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_wdata (bus_wdata),
        .load      (load),
        .load_data (load_data)
    );

    rsp_tx_shift #(
        .DATA_W (DATA_W)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .shift     (sck_fall),
        .load      (load),
        .load_data (load_data),
        .sdo       (sdo)
    );

    // R10: a power-down held over two cycles keeps the parallel side quiet
    a_r10_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down && $past(pwr_down)) |-> (!bus_we && !bus_re));

endmodule

// File: tb/rsp_serial_port_tb.sv
`timescale 1ns/1ps
module rsp_serial_port_tb;

    localparam int HALF = 10;
    localparam int WDOG = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_down = 1'b0;
    logic       sel = 1'b0;
    logic       sck = 1'b0;
    logic       sdi = 1'b0;
    logic       sdo;
    logic [6:0] bus_addr;
    logic       bus_we;
    logic       bus_re;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;

    int    n_checks = 0;
    int    n_err = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    logic [7:0] mem [128];
    int         exp_addr_q[$];
    int         exp_data_q[$];
    string      exp_tag_q[$];

    always #10 clk = ~clk;

    rsp_serial_port u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_down  (pwr_down),
        .sel       (sel),
        .sck       (sck),
        .sdi       (sdi),
        .sdo       (sdo),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    // Storage model: registered read, write on strobe.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) mem[i] <= 8'((i * 37 + 11) & 255);
            bus_rdata <= 8'h00;
        end else begin
            if (bus_we) mem[bus_addr] <= bus_wdata;
            if (bus_re) bus_rdata <= mem[bus_addr];
        end
    end

    function automatic bit b_mapped(int a);
        return (a < 32) || (a >= 32 && a < 48);
    endfunction

    function automatic int b_next(int a);
        if (a == 31) return 0;
        if (a == 47) return 32;
        return (a + 1) % 128;
    endfunction

    task automatic check(string req, int act, int exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: every write strobe is matched against the expected queue.
    always @(negedge clk) begin
        if (rst_n && bus_we) begin
            if (exp_addr_q.size() == 0) begin
                check(cur_req, 1, 0, $sformatf("unexpected write addr=%0h", bus_addr));
            end else begin
                automatic int    ea = exp_addr_q.pop_front();
                automatic int    ed = exp_data_q.pop_front();
                automatic string et = exp_tag_q.pop_front();
                check(et, int'(bus_addr), ea, "write address");
                check(et, int'(bus_wdata), ed, "write data");
            end
        end
    end

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - nbits; i--) begin
            sdi = tx[i];
            wait_clk(HALF);
            sck = 1'b1;
            rx[i] = sdo;
            wait_clk(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic sel_on();
        sel = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic sel_off();
        wait_clk(HALF);
        sel = 1'b0;
        wait_clk(2 * HALF);
    endtask

    // Burst write of n bytes; expected writes are queued for the monitor.
    task automatic do_write(string req, int start, int n, int seed);
        logic [7:0] rx;
        int a = start;
        sel_on();
        shift_bits({1'b1, 7'(start)}, 8, rx);
        for (int k = 0; k < n; k++) begin
            logic [7:0] d = 8'((seed + k * 29) & 255);
            if (b_mapped(a)) begin
                exp_addr_q.push_back(a);
                exp_data_q.push_back(int'(d));
                exp_tag_q.push_back(req);
            end
            shift_bits(d, 8, rx);
            a = b_next(a);
        end
        sel_off();
        check(req, exp_addr_q.size(), 0, "writes still pending");
    endtask

    // Burst read of n bytes, compared with the storage at expected addresses.
    task automatic do_read(string req, int start, int n);
        logic [7:0] rx;
        int a = start;
        sel_on();
        shift_bits({1'b0, 7'(start)}, 8, rx);
        for (int k = 0; k < n; k++) begin
            automatic int exp = b_mapped(a) ? int'(mem[a]) : 0;
            shift_bits(8'h00, 8, rx);
            check(req, int'(rx), exp, $sformatf("read byte at %0h", a));
            a = b_next(a);
        end
        sel_off();
    endtask

    initial begin
        logic [7:0] rx;
        wait_clk(4);
        check("R1", int'(sdo), 0, "sdo in reset");
        check("R1", int'(bus_we), 0, "bus_we in reset");
        check("R1", int'(bus_re), 0, "bus_re in reset");
        rst_n = 1'b1;
        wait_clk(1);
        check("R1", int'(sdo), 0, "sdo after reset");
        check("R1", int'(bus_we | bus_re), 0, "strobes after reset");

        // R2 R3 R5: burst write into RAM, then read it back (R4)
        cur_req = "R3";
        do_write("R3", 5, 3, 8'hA5);
        cur_req = "R4";
        do_read("R4", 5, 3);
        do_read("R5", 4, 4);

        // R6: RAM region wraps
        cur_req = "R6";
        do_write("R6", 30, 3, 8'h3C);
        do_read("R6", 30, 3);

        // R7: register region wraps
        cur_req = "R7";
        do_write("R7", 46, 3, 8'h71);
        do_read("R7", 46, 3);

        // R8: unmapped space, and wrap from the top of the address space
        cur_req = "R8";
        do_write("R8", 127, 2, 8'hC3);
        do_read("R8", 62, 3);
        do_read("R8", 127, 2);

        // R9: abort mid-byte, then a fresh header must work
        cur_req = "R9";
        sel_on();
        shift_bits(8'h85, 8, rx);
        shift_bits(8'hF0, 4, rx);
        sel_off();
        check("R9", exp_addr_q.size(), 0, "no write from partial byte");
        do_write("R9", 8, 1, 8'h5A);
        do_read("R9", 5, 1);

        // R10: power-down ignores traffic, sdo stays low
        cur_req = "R10";
        pwr_down = 1'b1;
        wait_clk(4);
        sel_on();
        shift_bits(8'h86, 8, rx);
        shift_bits(8'hEE, 8, rx);
        sel_off();
        sel_on();
        shift_bits(8'h06, 8, rx);
        shift_bits(8'h00, 8, rx);
        check("R10", int'(rx), 0, "sdo during power-down read");
        sel_off();
        pwr_down = 1'b0;
        wait_clk(4);
        do_read("R10", 6, 1);

        // R11: serial clock with select low has no effect
        cur_req = "R11";
        sdi = 1'b1;
        for (int i = 0; i < 12; i++) begin
            wait_clk(HALF);
            sck = ~sck;
            check("R11", int'(sdo), 0, "sdo while deselected");
        end
        sck = 1'b0;
        wait_clk(4 * HALF);
        check("R11", exp_addr_q.size(), 0, "no writes while deselected");
        do_read("R11", 8, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL %s watchdog expired actual=running expected=done", cur_req);
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

endmodule